// File: doc/BRIEF.md
# Two-Writer Last-Owner Table

This block tracks, for every address of a memory shared by two writers, which writer stored the newest value there. It is intended to sit next to a replicated data store in which writer A and writer B each own their own copy of the data. Each reader then uses a select bit from this block to pick the correct copy.

The block holds no data. It keeps two single-bit tables. Each table is written by one writer only, and each has three asynchronous read ports. When writer A writes an address, it copies the bit that table B holds there into table A. When writer B writes an address, it stores the complement of table A's bit into table B. A reader compares the two bits at its address. If they match, the newest value belongs to A; if they differ, it belongs to B. Because each storage bit has a single writer, neither table needs a second write port.

Top module: `lwt_owner_table`

## Requirements
- R1: While reset is held, and directly after it is released, every address reports side A. A select value of 0 means side A and a select value of 1 means side B.
- R2: After a clock edge at which writer A's enable is high with address x, a reader that presents address x reports 0. This holds while writer B does not write x at that same edge.
- R3: After a clock edge at which writer B's enable is high with address x, a reader that presents address x reports 1. This holds while writer A does not write x at that same edge.
- R4: Writes from both writers at the same edge to two different addresses both take effect. Each address then reports its own writer.
- R5: Reads are combinational on the stored tables. A reader that presents address x in the same cycle as a write to x reports the owner from before that write. The new owner appears in the following cycle.
- R6: An address that is not written keeps its reported owner across any number of cycles and across writes to other addresses.
- R7: The two readers are independent. Each may present any address, including the same address as the other reader or as a writer, and each gets that address's owner.
- R8: While a writer's enable is low, its address input has no effect on any stored owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both tables |
| wa_en | input | 1 | Writer A write enable |
| wa_addr | input | AW | Writer A address |
| wb_en | input | 1 | Writer B write enable |
| wb_addr | input | AW | Writer B address |
| rc_addr | input | AW | Reader C address |
| rd_addr | input | AW | Reader D address |
| rc_sel_b | output | 1 | Owner of rc_addr: 0 = writer A, 1 = writer B |
| rd_sel_b | output | 1 | Owner of rd_addr: 0 = writer A, 1 = writer B |

## Verification
The bench builds the block with DEPTH set to 16. With so few addresses, random traffic keeps producing the interesting overlaps: readers landing on an address being written in that same cycle, both readers on one address, and the same address being rewritten by alternating writers. Alternating owners is where the equal/unequal encoding must flip correctly both ways. The small depth also lets a directed sweep read back every address after reset and after a full fill by each writer.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

    // Owner encoding shared by readers and checks
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    // Read port slots of each owner table
    localparam int PORT_PEER = 0;
    localparam int PORT_RC   = 1;
    localparam int PORT_RD   = 2;
    localparam int NUM_RP    = 3;

endpackage

// File: rtl/lwt_bank.sv
module lwt_bank
    import lwt_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter bit INVERT = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic                      peer_bit,
    input  logic [NUM_RP-1:0][AW-1:0] raddr,
    output logic [NUM_RP-1:0]         rbit
);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } bank_state_t;

    bank_state_t state_d, state_q;
    logic        store_bit;

    // Parameter picks whether the peer bit is copied or complemented
    generate
        if (INVERT) begin : g_inv
            assign store_bit = ~peer_bit;
        end else begin : g_copy
            assign store_bit = peer_bit;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (we && (int'(waddr) < DEPTH)) begin
            state_d.bits[waddr] = store_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Asynchronous read ports
    generate
        for (genvar p = 0; p < NUM_RP; p++) begin : g_rd
            assign rbit[p] = (int'(raddr[p]) < DEPTH) ? state_q.bits[raddr[p]] : 1'b0;
        end
    endgenerate

    // R6 / R8: with the write enable low, no stored bit moves
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(state_q));

    // R6: at most one bit changes per write
    a_r6_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ($countones(state_q ^ $past(state_q)) <= 1));

endmodule

// File: rtl/lwt_pick.sv
module lwt_pick
    import lwt_pkg::*;
(
    input  logic bit_a,
    input  logic bit_b,
    output logic sel_b
);

    side_e side;

    always_comb begin
        side  = (bit_a == bit_b) ? SIDE_A : SIDE_B;
        sel_b = (side == SIDE_B);
    end

endmodule

// File: rtl/lwt_owner_table.sv
module lwt_owner_table
    import lwt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [AW-1:0] rc_addr,
    input  logic [AW-1:0] rd_addr,
    output logic          rc_sel_b,
    output logic          rd_sel_b
);

    localparam int NUM_RDR = 2;

    logic [NUM_RP-1:0][AW-1:0] ra_addr, rb_addr;
    logic [NUM_RP-1:0]         ra_bit, rb_bit;
    logic [NUM_RDR-1:0][AW-1:0] rdr_addr;
    logic [NUM_RDR-1:0]         rdr_sel;

    // Table A's peer port is read by writer B, and vice versa
    always_comb begin
        ra_addr[PORT_PEER] = wb_addr;
        ra_addr[PORT_RC]   = rc_addr;
        ra_addr[PORT_RD]   = rd_addr;
        rb_addr[PORT_PEER] = wa_addr;
        rb_addr[PORT_RC]   = rc_addr;
        rb_addr[PORT_RD]   = rd_addr;
        rdr_addr[0]        = rc_addr;
        rdr_addr[1]        = rd_addr;
    end

    lwt_bank #(.DEPTH(DEPTH), .AW(AW), .INVERT(1'b0)) i_bank_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wa_en),
        .waddr    (wa_addr),
        .peer_bit (rb_bit[PORT_PEER]),
        .raddr    (ra_addr),
        .rbit     (ra_bit)
    );

    lwt_bank #(.DEPTH(DEPTH), .AW(AW), .INVERT(1'b1)) i_bank_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wb_en),
        .waddr    (wb_addr),
        .peer_bit (ra_bit[PORT_PEER]),
        .raddr    (rb_addr),
        .rbit     (rb_bit)
    );

    generate
        for (genvar r = 0; r < NUM_RDR; r++) begin : g_reader
            lwt_pick i_pick (
                .bit_a (ra_bit[PORT_RC + r]),
                .bit_b (rb_bit[PORT_RC + r]),
                .sel_b (rdr_sel[r])
            );
        end
    endgenerate

    assign rc_sel_b = rdr_sel[0];
    assign rd_sel_b = rdr_sel[1];

    // R1: first cycle out of reset shows side A everywhere
    a_r1_reset_side_a: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rc_sel_b && !rd_sel_b));

    // R2: writer A's address reads back as side A one cycle later
    a_r2_a_owns: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wa_en) && !($past(wb_en) && $past(wb_addr) == $past(wa_addr))
         && rc_addr == $past(wa_addr)) |-> !rc_sel_b);

    // R3: writer B's address reads back as side B one cycle later
    a_r3_b_owns: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wb_en) && !($past(wa_en) && $past(wa_addr) == $past(wb_addr))
         && rd_addr == $past(wb_addr)) |-> rd_sel_b);

    // R6: with no writes and a steady address, the reported owner holds
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wa_en && !wb_en) && $stable(rc_addr)) |-> $stable(rc_sel_b));

    // R7: readers on the same address agree
    a_r7_readers_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_addr == rd_addr) |-> (rc_sel_b == rd_sel_b));

endmodule

// File: tb/test_lwt_owner_table.sv
`timescale 1ns/1ps
module test_lwt_owner_table;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wa_en = 1'b0, wb_en = 1'b0;
    logic [AW-1:0] wa_addr = '0, wb_addr = '0, rc_addr = '0, rd_addr = '0;
    logic          rc_sel_b, rd_sel_b;

    int checks = 0;
    int errors = 0;
    bit owner[DEPTH];   // 0 = A, 1 = B
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lwt_owner_table #(.DEPTH(DEPTH)) i_lwt_owner_table (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr),
        .wb_en(wb_en), .wb_addr(wb_addr),
        .rc_addr(rc_addr), .rd_addr(rd_addr),
        .rc_sel_b(rc_sel_b), .rd_sel_b(rd_sel_b)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, compare outputs, then apply the edge to the model
    task automatic step(string req, bit ae, int aa, bit be, int ba, int ca, int da);
        @(negedge clk);
        wa_en = ae; wa_addr = AW'(aa);
        wb_en = be; wb_addr = AW'(ba);
        rc_addr = AW'(ca); rd_addr = AW'(da);
        #1;
        check(req, rc_sel_b, owner[ca]);
        check(req, rd_sel_b, owner[da]);
        @(posedge clk);
        if (ae) owner[aa] = 1'b0;
        if (be) owner[ba] = 1'b1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) owner[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", rc_sel_b, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every address reports A after reset
        for (int i = 0; i < DEPTH; i += 2) step("R1", 0, 0, 0, 0, i, i + 1);
        // R3 then R2: B takes address 5, then A takes it back
        step("R3 write", 0, 0, 1, 5, 5, 5);          // R5: same-cycle read shows old owner A
        step("R3", 0, 0, 0, 0, 5, 5);
        step("R2 write", 1, 5, 0, 0, 5, 5);          // R5: still shows B
        step("R2", 0, 0, 0, 0, 5, 5);
        // R4: both writers, distinct addresses, same edge
        step("R4 write", 1, 3, 1, 9, 3, 9);
        step("R4", 0, 0, 0, 0, 3, 9);
        // R8: enables low with addresses pointing at owned entries
        step("R8 idle", 0, 9, 0, 3, 3, 9);
        step("R8", 0, 0, 0, 0, 9, 3);
        // R6: writes elsewhere leave 9 unchanged
        step("R6", 1, 1, 1, 2, 9, 9);
        step("R6", 0, 0, 0, 0, 9, 2);
        // Fill by B, then by A, read back all
        for (int i = 0; i < DEPTH; i++) step("R3 fill", 0, 0, 1, i, i, (i + 7) % DEPTH);
        for (int i = 0; i < DEPTH; i += 2) step("R3 sweep", 0, 0, 0, 0, i, i + 1);
        for (int i = 0; i < DEPTH; i++) step("R2 fill", 1, i, 0, 0, i, (i + 3) % DEPTH);
        for (int i = 0; i < DEPTH; i += 2) step("R2 sweep", 0, 0, 0, 0, i, i + 1);
        // R7 / R5 random traffic, writers on distinct addresses
        for (int n = 0; n < 3000; n++) begin
            int aa, ba;
            aa = $urandom_range(DEPTH - 1);
            ba = $urandom_range(DEPTH - 1);
            if (ba == aa) ba = (aa + 1) % DEPTH;
            step("R7 random", 1'($urandom), aa, 1'($urandom), ba,
                 $urandom_range(DEPTH - 1), $urandom_range(DEPTH - 1));
        end
        for (int i = 0; i < DEPTH; i += 2) step("R6 final", 0, 0, 0, 0, i, i + 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule